// File: doc/BRIEF.md
# Pipelined Inner-Product Error Unit

This block forms the error term of a delayed adaptive FIR filter. Each clock it accepts one new input sample, a full set of tap weights and one desired-signal sample. The sample is pushed into a tap delay line. The block then computes the filter output as the inner product of the weights and the delayed samples, and registers the error `desired - output`. The error is saturated to the output width. Weight adaptation happens outside this block, which sees the weights only as inputs.

Each product is split into radix-4 digits of the sample. One partial-product generator per tap turns each digit into a small multiple of the weight. All partial products that share a digit position are summed across the taps by one adder tree per digit. A shift-add tree then merges the per-digit sums by place value. Optional pipeline registers sit after the per-digit trees and after the merge. The desired sample is delayed by the same number of cycles, so it lines up with the filter output. The total latency is `LAT = 2 + PIPE_TREE + PIPE_MERGE` clock edges, which is 4 with the default parameters.

Top module: `ipe_error_unit`

## Requirements
- R1: While `rst_n` is low, and for the first LAT cycles after it rises, `err_out` is 0.
- R2: Inputs present before rising edge e first affect `err_out` right after edge e+LAT-1. With the default parameters, LAT is 4.
- R3: The filter output is y = sum over k of w_k * x(t-k). Here x(t-k) is the sample presented k cycles before the newest one, and tap 0 holds the newest sample.
- R4: Samples and weights are signed two's complement. Results are exact over the full range, including the most negative codes.
- R5: The weight of tap k is bits [k*WW +: WW] of `w_in`. The weights are taken in the same cycle as the newest sample, so a change of weights affects only outputs formed from that cycle onward.
- R6: `err_out` equals d - y exactly when the difference fits in EW bits. Here d is the desired sample presented in the same cycle as the newest sample.
- R7: When d - y exceeds 2^(EW-1)-1, `err_out` is 2^(EW-1)-1, which is 32767 by default.
- R8: When d - y is below -2^(EW-1), `err_out` is -2^(EW-1), which is -32768 by default.
- R9: An input of 1 followed by zeros, with d = 0, yields -w_0, -w_1, ..., -w_(TAPS-1) on successive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_in | input | XW | New input sample, signed |
| w_in | input | TAPS*WW | Tap weights, tap k in bits [k*WW +: WW], signed |
| d_in | input | DW | Desired sample, signed |
| err_out | output | EW | Registered, saturated error d - y |

## Verification
The bench targets the most negative sample code, whose top radix-4 digit must map to -2w or -w. A generator that treated that digit as unsigned would produce outputs that are off by a multiple of 4^(digits)·w. An impulse walks through the delay line; a wrong tap order or a wrong weight slice shows up as a permuted sequence of negated weights. Weights are switched every cycle to expose weights and samples taken in different cycles, which would mix adjacent weight sets. Differences just inside and well outside the output range catch clamping at the wrong bound or wraparound instead of saturation.

// File: rtl/ipe_pkg.sv
package ipe_pkg;

  // One-hot decode of a 2-bit digit: bit0 -> value 1, bit1 -> value 2, bit2 -> value 3
  function automatic logic [2:0] digit_decode(input logic [1:0] u);
    digit_decode = {u == 2'd3, u == 2'd2, u == 2'd1};
  endfunction

  // Multiple of w selected by one radix-4 digit; the top digit is signed (1, -2, -1)
  function automatic longint digit_product(input longint w, input logic [1:0] u, input logic top);
    logic [2:0] sel;
    longint m1, m2, m3;
    sel = digit_decode(u);
    m1 = w;
    m2 = top ? -(w <<< 1) : (w <<< 1);
    m3 = top ? -w : 3 * w;
    digit_product = (sel[0] ? m1 : 64'sd0) | (sel[1] ? m2 : 64'sd0) | (sel[2] ? m3 : 64'sd0);
  endfunction

  // Clamp v into a signed range of the given width
  function automatic longint clamp_to(input longint v, input int bits);
    longint hi, lo;
    hi = (longint'(1) <<< (bits - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) clamp_to = hi;
    else if (v < lo) clamp_to = lo;
    else clamp_to = v;
  endfunction

endpackage

// File: rtl/ipe_ppg.sv
module ipe_ppg #(
  parameter int XW   = 8,
  parameter int WW   = 8,
  parameter int PP_W = WW + 2
) (
  input  logic signed [XW-1:0]   x_i,
  input  logic signed [WW-1:0]   w_i,
  output logic signed [PP_W-1:0] pp_o [XW/2]
);
  localparam int DIGITS = XW / 2;

  for (genvar j = 0; j < DIGITS; j++) begin : g_digit
    localparam bit IS_TOP = (j == DIGITS - 1);
    assign pp_o[j] = PP_W'(ipe_pkg::digit_product(longint'(w_i), x_i[2*j +: 2], IS_TOP));
  end
endmodule

// File: rtl/ipe_add_tree.sv
// Binary tree over CNT inputs (power of two). Right children are shifted left by
// STEP bits per input in the left subtree: STEP=0 is a plain sum, STEP=2 merges
// radix-4 place values.
module ipe_add_tree #(
  parameter int CNT   = 4,
  parameter int IN_W  = 10,
  parameter int OUT_W = 12,
  parameter int STEP  = 0
) (
  input  logic signed [IN_W-1:0]  in_i [CNT],
  output logic signed [OUT_W-1:0] sum_o
);
  localparam int NODES = 2 * CNT - 1;

  logic signed [OUT_W-1:0] node [NODES];

  for (genvar i = 0; i < CNT; i++) begin : g_leaf
    assign node[CNT-1+i] = OUT_W'(in_i[i]);
  end

  for (genvar n = 0; n < CNT - 1; n++) begin : g_inner
    localparam int DEPTH = $clog2(n + 2) - 1;
    localparam int SH    = STEP * (CNT >> (DEPTH + 1));
    assign node[n] = node[2*n+1] + (node[2*n+2] <<< SH);
  end

  assign sum_o = node[0];
endmodule

// File: rtl/ipe_error_unit.sv
module ipe_error_unit #(
  parameter int TAPS       = 4,
  parameter int XW         = 8,
  parameter int WW         = 8,
  parameter int DW         = 16,
  parameter int EW         = 16,
  parameter bit PIPE_TREE  = 1'b1,
  parameter bit PIPE_MERGE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [XW-1:0]   x_in,
  input  logic [TAPS*WW-1:0]     w_in,
  input  logic signed [DW-1:0]   d_in,
  output logic signed [EW-1:0]   err_out
);
  localparam int DIGITS   = XW / 2;
  localparam int LOG_TAPS = $clog2(TAPS);
  localparam int PP_W     = WW + 2;
  localparam int PL_W     = PP_W + LOG_TAPS;
  localparam int ACC_W    = WW + XW + LOG_TAPS;
  localparam int DIF_W    = ((ACC_W > DW) ? ACC_W : DW) + 1;
  localparam int LAT      = 2 + int'(PIPE_TREE) + int'(PIPE_MERGE);
  localparam int DLY      = LAT - 1;
  localparam logic signed [DIF_W-1:0] EMAX = DIF_W'((longint'(1) <<< (EW - 1)) - 1);
  localparam logic signed [DIF_W-1:0] EMIN = -EMAX - DIF_W'(1);

  // Input stage: sample delay line and weight register
  logic signed [XW-1:0] xr [TAPS];
  logic signed [WW-1:0] wr [TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        xr[k] <= '0;
        wr[k] <= '0;
      end
    end else begin
      xr[0] <= x_in;
      for (int k = 1; k < TAPS; k++) xr[k] <= xr[k-1];
      for (int k = 0; k < TAPS; k++) wr[k] <= w_in[k*WW +: WW];
    end
  end

  // Partial products, one generator per tap
  logic signed [PP_W-1:0] pp  [TAPS][DIGITS];
  logic signed [PP_W-1:0] col [DIGITS][TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    ipe_ppg #(.XW(XW), .WW(WW), .PP_W(PP_W)) u_ppg (
      .x_i (xr[k]),
      .w_i (wr[k]),
      .pp_o(pp[k])
    );
    for (genvar j = 0; j < DIGITS; j++) begin : g_tr
      assign col[j][k] = pp[k][j];
    end
  end

  // Per-digit sums across taps
  logic signed [PL_W-1:0] pl_sum [DIGITS];
  logic signed [PL_W-1:0] pl_q   [DIGITS];

  for (genvar j = 0; j < DIGITS; j++) begin : g_place
    ipe_add_tree #(.CNT(TAPS), .IN_W(PP_W), .OUT_W(PL_W), .STEP(0)) u_place (
      .in_i (col[j]),
      .sum_o(pl_sum[j])
    );
  end

  if (PIPE_TREE) begin : g_tree_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int j = 0; j < DIGITS; j++) pl_q[j] <= '0;
      end else begin
        for (int j = 0; j < DIGITS; j++) pl_q[j] <= pl_sum[j];
      end
    end
  end else begin : g_tree_wire
    for (genvar j = 0; j < DIGITS; j++) begin : g_pass
      assign pl_q[j] = pl_sum[j];
    end
  end

  // Shift-add merge by place value
  logic signed [ACC_W-1:0] y_comb, y_q;

  ipe_add_tree #(.CNT(DIGITS), .IN_W(PL_W), .OUT_W(ACC_W), .STEP(2)) u_merge (
    .in_i (pl_q),
    .sum_o(y_comb)
  );

  if (PIPE_MERGE) begin : g_merge_reg
    always_ff @(posedge clk) begin
      if (!rst_n) y_q <= '0;
      else        y_q <= y_comb;
    end
  end else begin : g_merge_wire
    assign y_q = y_comb;
  end

  // Desired-signal alignment
  logic signed [DW-1:0] d_sh [DLY];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DLY; i++) d_sh[i] <= '0;
    end else begin
      d_sh[0] <= d_in;
      for (int i = 1; i < DLY; i++) d_sh[i] <= d_sh[i-1];
    end
  end

  // Error and saturation, with named events
  logic signed [DIF_W-1:0] diff_w;
  logic                    sat_hi_w, sat_lo_w;

  assign diff_w   = DIF_W'(d_sh[DLY-1]) - DIF_W'(y_q);
  assign sat_hi_w = diff_w > EMAX;
  assign sat_lo_w = diff_w < EMIN;

  always_ff @(posedge clk) begin
    if (!rst_n) err_out <= '0;
    else        err_out <= EW'(ipe_pkg::clamp_to(longint'(diff_w), EW));
  end
endmodule

// File: rtl/ipe_error_unit_chk.sv
module ipe_error_unit_chk #(
  parameter int EW    = 16,
  parameter int DIF_W = 19,
  parameter int LAT   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sat_hi,
  input logic                    sat_lo,
  input logic signed [DIF_W-1:0] diff,
  input logic signed [EW-1:0]    err
);
  localparam logic signed [EW-1:0] OMAX = {1'b0, {(EW-1){1'b1}}};
  localparam logic signed [EW-1:0] OMIN = {1'b1, {(EW-1){1'b0}}};
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LAT);

  logic [CW-1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)           cyc <= '0;
    else if (cyc != CMAX) cyc <= cyc + 1'b1;
  end

  // R1
  startup_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc < CMAX) |-> (err == '0));

  // R7
  clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hi |=> (err == OMAX));

  // R8
  clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_lo |=> (err == OMIN));

  // R6
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_hi && !sat_lo) |=> (err == $past(diff[EW-1:0])));

  // R7
  sat_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sat_hi, sat_lo}));
endmodule

bind ipe_error_unit ipe_error_unit_chk #(.EW(EW), .DIF_W(DIF_W), .LAT(LAT)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sat_hi(sat_hi_w),
  .sat_lo(sat_lo_w),
  .diff  (diff_w),
  .err   (err_out)
);

// File: tb/ipe_error_unit_tb.sv
`timescale 1ns/1ps
module ipe_error_unit_tb_top;
  localparam int LAT  = 4;
  localparam int TAPS = 4;
  localparam int HIST = 512;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [7:0]  x_in = '0;
  logic [31:0]        w_in = '0;
  logic signed [15:0] d_in = '0;
  logic signed [15:0] err_out;

  int  n_checks = 0;
  int  n_fails  = 0;
  int  idx      = 0;
  bit  done     = 1'b0;

  logic signed [7:0]  hx [HIST];
  logic signed [7:0]  hw [HIST][TAPS];
  logic signed [15:0] hd [HIST];

  always #2.5 clk = ~clk;

  ipe_error_unit dut_i (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .w_in(w_in), .d_in(d_in), .err_out(err_out)
  );

  // Reference: direct multiply-accumulate over recorded history, then clamp
  function automatic longint model_err(int m);
    int src;
    longint y, v;
    src = m - LAT;
    if (src < 0) return 0;
    y = 0;
    for (int k = 0; k < TAPS; k++)
      if (src - k >= 0) y += longint'(hw[src][k]) * longint'(hx[src-k]);
    v = longint'(hd[src]) - y;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  task automatic check_val(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s step %0d: actual=%0d expected=%0d", tag, idx, act, exp);
    end
  endtask

  task automatic step(input logic signed [7:0] x, input logic signed [7:0] w0, w1, w2, w3,
                      input logic signed [15:0] d, input string tag);
    @(negedge clk);
    check_val(tag, longint'(err_out), model_err(idx));
    x_in = x;
    w_in = {w3, w2, w1, w0};
    d_in = d;
    if (idx < HIST) begin
      hx[idx] = x; hd[idx] = d;
      hw[idx][0] = w0; hw[idx][1] = w1; hw[idx][2] = w2; hw[idx][3] = w3;
    end
    idx++;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check_val("R1 in reset", longint'(err_out), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    check_val("R1 release", longint'(err_out), 0);
    hx[0] = '0; hd[0] = '0;
    for (int k = 0; k < TAPS; k++) hw[0][k] = '0;
    idx = 1;
    // first LAT outputs after release stay zero
    for (int i = 0; i < LAT; i++) step(8'sd9, 8'sd3, 8'sd3, 8'sd3, 8'sd3, 16'sd50, "R1 startup");
  endtask

  task automatic t_impulse();
    step(8'sd1, 8'sd5, -8'sd3, 8'sd7, -8'sd128, 16'sd0, "R9 R2 impulse");
    for (int i = 0; i < 8; i++) step(8'sd0, 8'sd5, -8'sd3, 8'sd7, -8'sd128, 16'sd0, "R9 R2 impulse");
  endtask

  task automatic t_stream();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[7:0], 8'sd12, -8'sd7, 8'sd33, -8'sd90,
           16'(signed'({{6{lfsr[15]}}, lfsr[15:6]})), "R3 R6 stream");
    end
    for (int i = 0; i < LAT; i++) step(8'sd0, 8'sd12, -8'sd7, 8'sd33, -8'sd90, 16'sd0, "R3 flush");
  endtask

  task automatic t_extremes();
    for (int i = 0; i < 6; i++) step(-8'sd128, -8'sd128, 8'sd0, 8'sd0, 8'sd0, -16'sd100, "R4 min codes");
    for (int i = 0; i < 6; i++) step((i % 2) ? 8'sd127 : -8'sd128, 8'sd1, -8'sd128, 8'sd127, 8'sd1,
                                     16'sd7, "R4 alternating");
    for (int i = 0; i < LAT; i++) step(8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 16'sd0, "R4 flush");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 6; i++) step(-8'sd128, 8'sd127, 8'sd127, 8'sd127, 8'sd127, 16'sd32767, "R7 high");
    for (int i = 0; i < 6; i++) step(8'sd0, 8'sd127, 8'sd127, 8'sd127, 8'sd127, 16'sd32767, "R6 R7 edge");
    for (int i = 0; i < 6; i++) step(8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, -16'sd32768, "R6 R8 edge");
    for (int i = 0; i < 6; i++) step(8'sd127, 8'sd127, 8'sd127, 8'sd127, 8'sd127, -16'sd32768, "R8 low");
    for (int i = 0; i < LAT; i++) step(8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 16'sd0, "R8 flush");
  endtask

  task automatic t_weight_switch();
    for (int i = 0; i < 16; i++) begin
      if (i % 2) step(8'sd37, 8'sd100, 8'sd0, 8'sd0, -8'sd1, 16'sd1000, "R5 switch");
      else       step(8'sd37, -8'sd50, 8'sd9, 8'sd60, 8'sd0, 16'sd1000, "R5 switch");
    end
    for (int i = 0; i < LAT + 1; i++) step(8'sd0, 8'sd0, 8'sd0, 8'sd0, 8'sd0, 16'sd0, "R5 flush");
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_stream();
    t_extremes();
    t_saturate();
    t_weight_switch();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule